// File: doc/BRIEF.md
# Sequential Unsigned Multiply-Add With Split Result

This block multiplies two unsigned words and adds a third unsigned word in one operation. The addend is widened with zeros to double width before the add. The result comes back as two single-width words. The low word holds the bottom half of the full sum. The high word holds the top half.

The high word is meant to be wired back as the addend of the next operation. A scalar-by-vector big-integer multiply then becomes a chain of operations: each one multiplies the scalar by the next vector element and adds in the carry word from the operation before. Every operation writes out one low word, and the final high word is the most significant word of the product.

The unit works over several cycles. A shift-and-add datapath consumes a few multiplier bits per cycle, with the digit size set by a parameter. A start pulse loads the operands and raises busy. A one-cycle done pulse marks the moment both result words are valid. The number of cycles does not depend on the operand values.

Top module: `umac_seq`

## Requirements
- R1: During and after reset, busy_o and done_o are 0 and both result words are 0.
- R2: After an operation completes, {res_hi_o, res_lo_o} equals mul_a_i * mul_b_i + add_c_i computed as a 2*WIDTH-bit unsigned value.
- R3: The addend is zero-extended and never sign-extended. With mul_a_i = 0 and add_c_i having its top bit set, res_hi_o is 0 and res_lo_o equals add_c_i.
- R4: res_lo_o equals (mul_a_i * mul_b_i + add_c_i) mod 2^WIDTH for every operand combination.
- R5: The double-width sum never carries out. With all three operands at their maximum value, res_hi_o is all ones and res_lo_o is zero.
- R6: If the res_hi_o of one operation is fed as add_c_i of the next, a sequence of operations produces the exact product of a scalar and a multi-word vector. Each operation contributes one low word, and the last res_hi_o is the top word.
- R7: A start_i pulse while busy_o is 1 is ignored. The running operation and its result are unaffected.
- R8: done_o is high for exactly one cycle per accepted start. Both result words stay stable from that cycle until the next accepted start.
- R9: A start is accepted when start_i is 1 at a clock edge while busy_o is 0. busy_o is then 1 for STEPS = WIDTH/DIGIT_BITS cycles. done_o rises at the STEPS-th edge after the accepting edge, the same edge at which busy_o falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation; accepted only while idle |
| mul_a_i | input | WIDTH | Multiplicand, sampled on an accepted start |
| mul_b_i | input | WIDTH | Multiplier, sampled on an accepted start |
| add_c_i | input | WIDTH | Addend, zero-extended, sampled on an accepted start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when both result words are valid |
| res_lo_o | output | WIDTH | Low half of the double-width sum |
| res_hi_o | output | WIDTH | High half of the double-width sum |

## Verification
Zero operands and a large addend with its top bit set show whether the addend is widened with zeros or with its sign. All-ones operands drive the sum to its largest value, which exposes any lost carry in the top digit. Single-bit and alternating-bit multipliers catch digit-ordering and shift-amount errors that random data can hide. A four-word chained product, compared against a wide reference multiply, shows whether the carry word is handed correctly between operations. A start pulse issued mid-operation with different operands shows whether the running result is disturbed.

// File: rtl/umac_pkg.sv
// Package: shared parameters and helpers for the sequential multiply-add.
// Assumes WIDTH is a multiple of the digit size chosen by the top.
package umac_pkg;
    localparam int unsigned UMAC_WIDTH_DEF = 64;
    localparam int unsigned UMAC_DIGIT_DEF = 2;

    // Number of shift-and-add steps for a given word width and digit size.
    function automatic int unsigned umac_steps(input int unsigned width, input int unsigned digit);
        return width / digit;
    endfunction
endpackage

// File: rtl/umac_ctrl.sv
// Module: umac_ctrl
// Sequences one operation: accepts a start while idle, keeps busy high for
// STEPS cycles, then pulses done for exactly one cycle.
// Assumes: STEPS >= 2; a start seen while busy is dropped.
module umac_ctrl #(
    parameter int unsigned STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    assign load_o = start_i && !busy_q;
    assign step_o = busy_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    // Busy flag, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // R7: a start during busy does not restart the step count
    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

    // R8: done is a single-cycle pulse
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R9: done and busy are never high together
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
endmodule

// File: rtl/umac_pp.sv
// Module: umac_pp
// Forms one partial product: the shifted multiplicand times a DIGIT-bit
// multiplier digit, built as a sum of selected shifted copies.
// Assumes the caller keeps the multiplicand small enough that no set bit is
// shifted past the top of the DW-bit result.
module umac_pp #(
    parameter int unsigned DW    = 128,
    parameter int unsigned DIGIT = 2
) (
    input  logic [DW-1:0]    mcand_i,
    input  logic [DIGIT-1:0] digit_i,
    output logic [DW-1:0]    pp_o
);
    logic [DW-1:0] term [DIGIT];

    for (genvar g = 0; g < DIGIT; g++) begin : g_term
        assign term[g] = digit_i[g] ? (mcand_i << g) : '0;
    end

    // Adds the selected shifted copies.
    always_comb begin
        pp_o = '0;
        for (int j = 0; j < DIGIT; j++) begin
            pp_o = pp_o + term[j];
        end
    end
endmodule

// File: rtl/umac_dp.sv
// Module: umac_dp
// Datapath: on load it sets the accumulator to the zero-extended addend and
// captures both factors. On each step it adds one partial product, shifts the
// multiplicand left by one digit and shifts the multiplier right by one digit.
// Assumes: load and step are never high together.
module umac_dp #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned DIGIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] c_i,
    output logic [WIDTH-1:0] lo_o,
    output logic [WIDTH-1:0] hi_o
);
    localparam int unsigned DW = 2 * WIDTH;

    logic [DW-1:0]    acc_q;
    logic [DW-1:0]    mcand_q;
    logic [WIDTH-1:0] mplier_q;
    logic [DW-1:0]    pp;
    logic [DW:0]      sum_ext;

    umac_pp #(.DW(DW), .DIGIT(DIGIT)) u_pp (
        .mcand_i (mcand_q),
        .digit_i (mplier_q[DIGIT-1:0]),
        .pp_o    (pp)
    );

    assign sum_ext = {1'b0, acc_q} + {1'b0, pp};
    assign lo_o    = acc_q[WIDTH-1:0];
    assign hi_o    = acc_q[DW-1:WIDTH];

    // Loads the operands or performs one shift-and-add step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load_i) begin
            acc_q    <= {{WIDTH{1'b0}}, c_i};
            mcand_q  <= {{WIDTH{1'b0}}, a_i};
            mplier_q <= b_i;
        end else if (step_i) begin
            acc_q    <= sum_ext[DW-1:0];
            mcand_q  <= mcand_q << DIGIT;
            mplier_q <= mplier_q >> DIGIT;
        end
    end

    // R5: the running double-width sum never carries out
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !sum_ext[DW]);

    // R3: right after a load, the top half is zero (addend widened with zeros)
    assert_zero_extend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (hi_o == '0));
endmodule

// File: rtl/umac_seq.sv
// Module: umac_seq (top)
// Sequential unsigned A*B+C. The result is returned as low and high words.
// The high word is intended to be chained in as the next addend.
// Assumes: WIDTH divisible by DIGIT_BITS; operands are sampled only on an
// accepted start.
module umac_seq #(
    parameter int unsigned WIDTH      = umac_pkg::UMAC_WIDTH_DEF,
    parameter int unsigned DIGIT_BITS = umac_pkg::UMAC_DIGIT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] mul_a_i,
    input  logic [WIDTH-1:0] mul_b_i,
    input  logic [WIDTH-1:0] add_c_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] res_lo_o,
    output logic [WIDTH-1:0] res_hi_o
);
    localparam int unsigned STEPS = umac_pkg::umac_steps(WIDTH, DIGIT_BITS);
    localparam int unsigned LAT_W = $clog2(STEPS) + 1;

    logic load;
    logic step;

    umac_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    umac_dp #(.WIDTH(WIDTH), .DIGIT(DIGIT_BITS)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .a_i    (mul_a_i),
        .b_i    (mul_b_i),
        .c_i    (add_c_i),
        .lo_o   (res_lo_o),
        .hi_o   (res_hi_o)
    );

    // Checker counter: edges since the last accepted start (R9).
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                lat_q <= '0;
        else if (start_i && !busy_o) lat_q <= '0;
        else if (busy_o)           lat_q <= lat_q + 1'b1;
    end

    // R9: done arrives exactly STEPS edges after the accepting edge
    assert_fixed_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == LAT_W'(STEPS)));

    // R8: results hold while idle with no new start
    assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(res_lo_o) && $stable(res_hi_o)));

    // R1: reset state of the handshake outputs
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && res_lo_o == '0 && res_hi_o == '0));
endmodule

// File: tb/umac_seq_bench.sv
module umac_seq_bench;
    localparam int W     = 64;
    localparam int STEPS = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] mul_a_i = '0, mul_b_i = '0, add_c_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] res_lo_o, res_hi_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    umac_seq u_umac_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mul_a_i(mul_a_i), .mul_b_i(mul_b_i), .add_c_i(add_c_i),
        .busy_o(busy_o), .done_o(done_o),
        .res_lo_o(res_lo_o), .res_hi_o(res_hi_o)
    );

    // Behavioural reference model, advanced on every rising edge.
    logic           m_busy = 0, m_done = 0;
    int             m_cnt = 0;
    logic [2*W-1:0] m_pend = '0, m_res = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
        end else begin
            m_done = 0;
            if (!m_busy && start_i) begin
                m_busy = 1; m_cnt = 0;
                m_pend = {{W{1'b0}}, mul_a_i} * {{W{1'b0}}, mul_b_i} + {{W{1'b0}}, add_c_i};
            end else if (m_busy) begin
                m_cnt++;
                if (m_cnt == STEPS) begin
                    m_busy = 0; m_done = 1; m_res = m_pend;
                end
            end
        end
    end

    // Compares the design to the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (busy_o !== m_busy) begin
                bad++; $display("FAIL R9 busy act=%0b exp=%0b", busy_o, m_busy);
            end
            total++;
            if (done_o !== m_done) begin
                bad++; $display("FAIL R8 done act=%0b exp=%0b", done_o, m_done);
            end
            if (!m_busy) begin
                total++;
                if ({res_hi_o, res_lo_o} !== m_res) begin
                    bad++; $display("FAIL R2 result act=%h exp=%h", {res_hi_o, res_lo_o}, m_res);
                end
            end
        end
    end

    task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++; $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Runs one operation. Optionally fires a stray start mid-run with other operands.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                          input bit stray, output logic [W-1:0] lo, output logic [W-1:0] hi);
        @(negedge clk);
        mul_a_i = a; mul_b_i = b; add_c_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mul_a_i = ~a; mul_b_i = ~b; add_c_i = ~c;
        for (int i = 0; i < STEPS + 4 && !done_o; i++) begin
            if (stray && i == 5) start_i = 1'b1;
            else start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        lo = res_lo_o; hi = res_hi_o;
        // R8: values must hold over idle cycles after done
        repeat (3) @(negedge clk);
        check("R8 hold", {res_hi_o, res_lo_o}, {hi, lo});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] lo, hi, carry;
        logic [W-1:0] vec [4];
        logic [5*W-1:0] wide_exp, wide_act;
        logic [W-1:0] s;
        repeat (3) @(negedge clk);
        check("R1 reset", {res_hi_o, res_lo_o, 62'b0, busy_o, done_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: zero multiplicand, addend with top bit set
        run_op('0, 64'h1234_5678_9abc_def0, 64'hF000_0000_0000_0001, 0, lo, hi);
        check("R3", {hi, lo}, {64'h0, 64'hF000_0000_0000_0001});

        // R5: all-ones operands
        run_op('1, '1, '1, 0, lo, hi);
        check("R5", {hi, lo}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0});

        // R4: low word modulo check, single-bit and alternating patterns
        run_op(64'h8000_0000_0000_0000, 64'h2, 64'h5, 0, lo, hi);
        check("R4", {hi, lo}, {64'h1, 64'h5});
        run_op(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 64'h0, 0, lo, hi);
        check("R2", {hi, lo}, {64'h0, 64'hAAAA_AAAA_AAAA_AAAA} * {64'h0, 64'h5555_5555_5555_5555});
        run_op(64'hDEAD_BEEF_0123_4567, 64'hFEDC_BA98_7654_3210, 64'hCAFE_F00D_1111_2222, 0, lo, hi);
        check("R4", {64'h0, lo},
              {64'h0, 64'hDEAD_BEEF_0123_4567 * 64'hFEDC_BA98_7654_3210 + 64'hCAFE_F00D_1111_2222});

        // R7: stray start during busy must not disturb the result
        run_op(64'h0123_4567_89AB_CDEF, 64'h0F0F_0F0F_0F0F_0F0F, 64'h77, 1, lo, hi);
        check("R7", {hi, lo}, {64'h0, 64'h0123_4567_89AB_CDEF} * {64'h0, 64'h0F0F_0F0F_0F0F_0F0F} + 128'h77);

        // R6: chained scalar-by-vector product
        s = 64'hFFFF_FFFF_0000_0001;
        vec[0] = 64'hFFFF_FFFF_FFFF_FFFF; vec[1] = 64'h1357_9BDF_2468_ACE0;
        vec[2] = 64'h8000_0000_0000_0001; vec[3] = 64'hFFFF_0000_FFFF_0000;
        carry = '0;
        wide_act = '0;
        for (int k = 0; k < 4; k++) begin
            run_op(vec[k], s, carry, 0, lo, hi);
            wide_act[k*W +: W] = lo;
            carry = hi;
        end
        wide_act[4*W +: W] = carry;
        wide_exp = {{W{1'b0}}, vec[3], vec[2], vec[1], vec[0]} * {{(4*W){1'b0}}, s};
        total++;
        if (wide_act !== wide_exp) begin
            bad++; $display("FAIL R6 chain act=%h exp=%h", wide_act, wide_exp);
        end

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule